// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Pad Control

This block is one bank of eight general-purpose pins behind a small register port. Software picks a function for each pin, sets its output level, and chooses a pull resistor, a drive strength and a slew rate. The pad side carries, for each pin, an output enable, an output value, pull-up and pull-down controls, a 2-bit strength code and a slew bit. It also takes the level sampled at each pad. A chip with more pins uses several banks. Flat pin number N sits in bank N/8 at position N%8, and that decode is done outside the bank.

The register port is plain, not a stream. A write is taken on any rising clock edge where `reg_we` is high. A read is combinational from `reg_addr`. There is no back-pressure and every access completes in one cycle. To make a pin an output, software first writes its function field with the output code and then writes the data register with the level it wants. The data bit is stored even while the pin is not an output, so it can be set up before the pin is switched.

Top module: `gpio_bank_pad`

## Requirements
- R1: Reset is synchronous and active low. After reset every function field holds the input code 0, and the data, pull, strength and slew registers are all zero. So `pad_oe`, `pad_pu`, `pad_pd`, `pad_out`, `pad_drv` and `pad_slew` are all zero.
- R2: Address 0 is the function register. Pin i owns bits [4i+3:4i]. A write stores all 32 bits and a read returns them unchanged.
- R3: `pad_oe[i]` is 1 exactly when pin i's function field holds the output code 1, and it follows a write on the next clock.
- R4: Address 1 is the data register. Pin i owns bit i. A write sets `pad_out` to `wdata[7:0]` on the next clock, and bits 31:8 read as zero.
- R5: A read of address 1 returns the stored bit for pins in output mode. For every other pin it returns `pad_in[i]` after a two-flop synchronizer. A change on `pad_in` shows in the read after the second rising edge and not after the first.
- R6: Address 2 is the pull register. Pin i owns bits [2i+1:2i]. Code 1 drives `pad_pd[i]` and code 3 drives `pad_pu[i]`. Codes 0 and 2 drive neither. Bits 31:16 read as zero.
- R7: Address 3 is the drive register. Bits [2i+1:2i] carry pin i's strength code, where 0 to 3 select 1x to 4x, and go to `pad_drv[2i+1:2i]`. Bit 16+i is pin i's slew select and goes to `pad_slew[i]`. Bits 31:24 read as zero.
- R8: When `reg_we` is low, nothing changes on the pad controls or in the registers. A write to one address leaves the other three registers unchanged.
- R9: Function codes 2 to 15 are reserved. For such a pin `pad_oe` is low and the data read returns the synchronized pad level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 2 | Register select (0 function, 1 data, 2 pull, 3 drive) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | 8 | Sampled pad levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_pd | output | 8 | Per-pin pull-down enable |
| pad_drv | output | 16 | Per-pin 2-bit drive strength code |
| pad_slew | output | 8 | Per-pin slew select |

## Verification
All sixteen function codes are swept on every pin, one pin at a time. This separates the single output code from the input code and the reserved codes, and it shows any field that is placed wrongly or overlaps another. The four pull codes and the four strength codes, each with its slew bit, are swept on every pin in the same way, which separates pull-up from pull-down and the reserved pull code from no pull. Data reads use alternating output and input pins with different stored and external patterns, so a bit taken from the wrong source shows up. A timed edge on `pad_in` measures the synchronizer latency exactly.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
  localparam int unsigned FUNC_W    = 4;
  localparam int unsigned PULL_W    = 2;
  localparam int unsigned STR_W     = 2;
  localparam int unsigned SLEW_BASE = 16;

  localparam logic [FUNC_W-1:0] FN_INPUT  = 4'h0;
  localparam logic [FUNC_W-1:0] FN_OUTPUT = 4'h1;

  localparam logic [PULL_W-1:0] PULL_OFF  = 2'd0;
  localparam logic [PULL_W-1:0] PULL_DOWN = 2'd1;
  localparam logic [PULL_W-1:0] PULL_UP   = 2'd3;

  typedef enum logic [1:0] {
    SEL_FUNC  = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_PULL  = 2'd2,
    SEL_DRIVE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
module gpb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpb_regs.sv
`timescale 1ns/1ps
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned CFG_BITS  = NPINS * FUNC_W,
  localparam int unsigned PULL_BITS = NPINS * PULL_W,
  localparam int unsigned STR_BITS  = NPINS * STR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [DW-1:0]        wdata,
  output logic [CFG_BITS-1:0]  cfg_q,
  output logic [NPINS-1:0]     dat_q,
  output logic [PULL_BITS-1:0] pull_q,
  output logic [STR_BITS-1:0]  str_q,
  output logic [NPINS-1:0]     slew_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= {NPINS{FN_INPUT}};
      dat_q  <= '0;
      pull_q <= {NPINS{PULL_OFF}};
      str_q  <= '0;
      slew_q <= '0;
    end else if (we) begin
      case (addr)
        SEL_FUNC:  cfg_q  <= wdata[CFG_BITS-1:0];
        SEL_DATA:  dat_q  <= wdata[NPINS-1:0];
        SEL_PULL:  pull_q <= wdata[PULL_BITS-1:0];
        default: begin
          str_q  <= wdata[STR_BITS-1:0];
          slew_q <= wdata[SLEW_BASE +: NPINS];
        end
      endcase
    end
  end
endmodule

// File: rtl/gpb_pin_ctrl.sv
`timescale 1ns/1ps
module gpb_pin_ctrl
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  localparam int unsigned CFG_BITS  = NPINS * FUNC_W,
  localparam int unsigned PULL_BITS = NPINS * PULL_W
) (
  input  logic [CFG_BITS-1:0]  cfg_q,
  input  logic [NPINS-1:0]     dat_q,
  input  logic [PULL_BITS-1:0] pull_q,
  input  logic [NPINS-1:0]     in_sync,
  output logic [NPINS-1:0]     oe,
  output logic [NPINS-1:0]     pu,
  output logic [NPINS-1:0]     pd,
  output logic [NPINS-1:0]     dat_rd
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [FUNC_W-1:0] fn;
    logic [PULL_W-1:0] pl;
    logic              is_out;

    assign fn     = cfg_q[p*FUNC_W +: FUNC_W];
    assign pl     = pull_q[p*PULL_W +: PULL_W];
    assign is_out = (fn == FN_OUTPUT);

    assign oe[p]     = is_out;
    assign pu[p]     = (pl == PULL_UP);
    assign pd[p]     = (pl == PULL_DOWN);
    assign dat_rd[p] = is_out ? dat_q[p] : in_sync[p];
  end
endmodule

// File: rtl/gpio_bank_pad.sv
`timescale 1ns/1ps
module gpio_bank_pad
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned CFG_BITS  = NPINS * FUNC_W,
  localparam int unsigned PULL_BITS = NPINS * PULL_W,
  localparam int unsigned STR_BITS  = NPINS * STR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_pu,
  output logic [NPINS-1:0]    pad_pd,
  output logic [STR_BITS-1:0] pad_drv,
  output logic [NPINS-1:0]    pad_slew
);
  logic [CFG_BITS-1:0]  cfg_q;
  logic [NPINS-1:0]     dat_q;
  logic [PULL_BITS-1:0] pull_q;
  logic [STR_BITS-1:0]  str_q;
  logic [NPINS-1:0]     slew_q;
  logic [NPINS-1:0]     in_sync;
  logic [NPINS-1:0]     dat_rd;

  gpb_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .cfg_q  (cfg_q),
    .dat_q  (dat_q),
    .pull_q (pull_q),
    .str_q  (str_q),
    .slew_q (slew_q)
  );

  gpb_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  gpb_pin_ctrl #(.NPINS(NPINS)) u_pins (
    .cfg_q   (cfg_q),
    .dat_q   (dat_q),
    .pull_q  (pull_q),
    .in_sync (in_sync),
    .oe      (pad_oe),
    .pu      (pad_pu),
    .pd      (pad_pd),
    .dat_rd  (dat_rd)
  );

  assign pad_out  = dat_q;
  assign pad_drv  = str_q;
  assign pad_slew = slew_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_FUNC:  reg_rdata[CFG_BITS-1:0]  = cfg_q;
      SEL_DATA:  reg_rdata[NPINS-1:0]     = dat_rd;
      SEL_PULL:  reg_rdata[PULL_BITS-1:0] = pull_q;
      default: begin
        reg_rdata[STR_BITS-1:0]       = str_q;
        reg_rdata[SLEW_BASE +: NPINS] = slew_q;
      end
    endcase
  end
endmodule

// File: rtl/gpb_checker.sv
`timescale 1ns/1ps
module gpb_checker #(
  parameter int unsigned NPINS = 8,
  parameter int unsigned DW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [1:0]         reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_pu,
  input logic [NPINS-1:0]   pad_pd,
  input logic [2*NPINS-1:0] pad_drv,
  input logic [NPINS-1:0]   pad_slew
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_out == '0));

  a_r4_data_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> pad_out == $past(reg_wdata[NPINS-1:0]));

  a_r6_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  a_r7_slew_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3) |=> pad_slew == $past(reg_wdata[16 +: NPINS]));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) &&
                 $stable(pad_pd) && $stable(pad_drv) && $stable(pad_slew)));

  for (genvar p = 0; p < NPINS; p++) begin : g_fn
    a_r3_oe_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0) |=> pad_oe[p] == ($past(reg_wdata[4*p +: 4]) == 4'h1));
  end
endmodule

bind gpio_bank_pad gpb_checker #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .pad_drv   (pad_drv),
  .pad_slew  (pad_slew)
);

// File: tb/sim_gpio_bank_pad.sv
`timescale 1ns/1ps
module sim_gpio_bank_pad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_in = 8'h00;
  logic [7:0]  pad_oe, pad_out, pad_pu, pad_pd, pad_slew;
  logic [15:0] pad_drv;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_bank_pad u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_drv(pad_drv), .pad_slew(pad_slew)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1 v = reg_rdata;
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pad_oe", {24'h0, pad_oe}, 0);
    chk("R1 pad_pu", {24'h0, pad_pu}, 0);
    chk("R1 pad_pd", {24'h0, pad_pd}, 0);
    chk("R1 pad_out", {24'h0, pad_out}, 0);
    chk("R1 pad_drv", {16'h0, pad_drv}, 0);
    chk("R1 pad_slew", {24'h0, pad_slew}, 0);
    rd(2'd0, v); chk("R1 func reg", v, 0);
    rd(2'd2, v); chk("R1 pull reg", v, 0);
    rd(2'd3, v); chk("R1 drive reg", v, 0);

    // R2 R3 R9 function sweep
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        wr(2'd0, 32'(c) << (4 * p));
        chk("R3 pad_oe per code", {24'h0, pad_oe}, (c == 1) ? (32'd1 << p) : 32'd0);
        rd(2'd0, v);
        chk("R2 func readback", v, 32'(c) << (4 * p));
      end
    end
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 full word", v, 32'hFFFF_FFFF);
    chk("R9 reserved code 15 no oe", {24'h0, pad_oe}, 0);

    // R6 pull sweep
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(2'd2, 32'(c) << (2 * p));
        chk("R6 pad_pu", {24'h0, pad_pu}, (c == 3) ? (32'd1 << p) : 32'd0);
        chk("R6 pad_pd", {24'h0, pad_pd}, (c == 1) ? (32'd1 << p) : 32'd0);
        rd(2'd2, v);
        chk("R6 pull readback", v, 32'(c) << (2 * p));
      end
    end
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R6 upper bits zero", v, 32'h0000_FFFF);

    // R7 drive and slew sweep
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 4; s++) begin
        wr(2'd3, (32'(s) << (2 * p)) | (32'(s & 1) << (16 + p)));
        chk("R7 pad_drv", {16'h0, pad_drv}, 32'(s) << (2 * p));
        chk("R7 pad_slew", {24'h0, pad_slew}, 32'(s & 1) << p);
      end
    end
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R7 upper bits zero", v, 32'h00FF_FFFF);

    // R8 register isolation and write-enable gating
    wr(2'd0, 32'h1111_1111);
    rd(2'd2, v); chk("R8 pull kept after func write", v, 32'h0000_FFFF);
    rd(2'd3, v); chk("R8 drive kept after func write", v, 32'h00FF_FFFF);
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 32'h0000_005A; reg_we = 1'b0;
    @(negedge clk);
    chk("R8 no write without we", {24'h0, pad_out}, 32'h0);
    reg_addr = 2'd0; reg_wdata = 32'h0;
    @(negedge clk);
    chk("R8 func kept without we", {24'h0, pad_oe}, 32'hFF);

    // R4 R5 data register, all output
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pat;
      pat = 8'h5A ^ 8'(k * 8'h33);
      wr(2'd1, {24'hFFFFFF, pat});
      chk("R4 pad_out", {24'h0, pad_out}, {24'h0, pat});
      pad_in = ~pat;
      repeat (3) @(negedge clk);
      rd(2'd1, v); chk("R5 output pins read stored bit", v, {24'h0, pat});
    end

    // R5 R9 mixed pins: even output, odd reserved code 2
    wr(2'd0, 32'h2121_2121);
    wr(2'd1, 32'h0000_00A5);
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd1, v);
    chk("R5 R9 mixed read", v, {24'h0, (8'hA5 & 8'h55) | (8'h3C & 8'hAA)});

    // R5 synchronizer latency, all input
    wr(2'd0, 32'h0);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    reg_addr = 2'd1;
    pad_in = 8'hC3;
    @(negedge clk); #1;
    chk("R5 not visible after one edge", reg_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R5 visible after two edges", reg_rdata, 32'h0000_00C3);
    chk("R5 input pins no oe", {24'h0, pad_oe}, 0);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 second reset drv", {16'h0, pad_drv}, 0);
    chk("R1 second reset out", {24'h0, pad_out}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule